// File: doc/BRIEF.md
# Vector extended integer divider

This block divides the lanes of one vector operand by the lanes of another, with the dividend of each lane formed as the lane of A shifted up by the full lane width. The low half of the double-width dividend is zero. The unit takes two 128-bit operands and a mode select for lane size: either two independent 64-bit lanes or one 128-bit lane. A second select chooses signed or unsigned arithmetic. The result is the low lane-width part of the quotient.

Cases where the architectural result is undefined are flagged and produce zero in the affected lane. These cases are a zero divisor, a dividend not smaller than the divisor, and a signed quotient that cannot be represented.

The unit runs a restoring shift-subtract on magnitudes and produces one quotient bit per clock. It is driven by a start pulse and reports its state through busy. A one-cycle done pulse marks the result.

Top module: `vxd_divider`

## Requirements
- R1: With `quad_i`=0 the operands are two independent 64-bit lanes: lane 0 is bits 63:0 and lane 1 is bits 127:64. With `quad_i`=1 all 128 bits form a single lane.
- R2: In unsigned mode (`signed_i`=0), a valid lane returns the low lane-width bits of floor((A << W) / B), where W is the lane width.
- R3: A lane whose divisor is zero returns zero.
- R4: In unsigned mode, a lane with A >= B, compared unsigned, returns zero.
- R5: In signed mode, a lane where |A| >= |B|, with the magnitudes compared as unsigned numbers, returns zero.
- R6: In signed mode, a valid lane returns the two's-complement quotient of (A << W) / B, truncated toward zero.
- R7: In signed mode, a lane whose quotient is outside the W-bit signed range returns zero. The range is -2^(W-1) to 2^(W-1)-1.
- R8: A start accepted while idle raises `busy_o` from the next cycle. `done_o` is high for exactly one cycle, at the (N+2)th rising edge counted from the edge that samples start, where N is 64 or 128. In that cycle `busy_o` is low and `result_o` carries the new result, which holds until the next done.
- R9: `start_i` is ignored while `busy_o` is high. Neither the operation in flight nor its result changes, and no second operation follows.
- R10: After reset, `busy_o`, `done_o` and `result_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new division, sampled when idle |
| signed_i | input | 1 | 1 = signed lanes, 0 = unsigned |
| quad_i | input | 1 | 1 = one 128-bit lane, 0 = two 64-bit lanes |
| a_i | input | 128 | Operand A, dividend upper half per lane |
| b_i | input | 128 | Operand B, divisor per lane |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 128 | Quotient vector, held between operations |

## Verification
The result is due 66 edges after the start edge for two 64-bit lanes and 130 edges after for one 128-bit lane, counting the start edge. Busy holds over the preceding 65 or 129 cycles. The bench keeps a behavioural model that counts the same edges from the accepted start and computes the quotient with wide arithmetic. On every falling edge it compares busy, done and the held result against that model, so an early or late pulse fails in the exact cycle it occurs. A bound checker independently counts busy cycles up to the done pulse.

// File: rtl/vxd_pkg.sv
package vxd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } vxd_state_e;

  localparam int unsigned VXD_LANES = 2;

  // A magnitude quotient fits the signed lane when its top bit is clear,
  // or when it is exactly 2^(W-1) and the result is to be negated.
  function automatic logic vxd_fits(input logic top, input logic rest_zero, input logic neg);
    return !top || (neg && rest_zero);
  endfunction

endpackage

// File: rtl/vxd_precheck.sv
module vxd_precheck #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sgn_i,
  input  logic             quad_i,
  output logic [VEC_W-1:0] mag_a_o,
  output logic [VEC_W-1:0] mag_b_o,
  output logic [1:0]       zero_o,
  output logic [1:0]       neg_o
);
  localparam int unsigned HW = VEC_W / 2;

  function automatic logic [VEC_W-1:0] mag_f(input logic [VEC_W-1:0] x, input logic n);
    return n ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [HW-1:0] mag_h(input logic [HW-1:0] x, input logic n);
    return n ? (~x + 1'b1) : x;
  endfunction

  // whole-vector lane
  logic             f_an, f_bn, f_zero;
  logic [VEC_W-1:0] f_ma, f_mb;
  assign f_an   = sgn_i & a_i[VEC_W-1];
  assign f_bn   = sgn_i & b_i[VEC_W-1];
  assign f_ma   = mag_f(a_i, f_an);
  assign f_mb   = mag_f(b_i, f_bn);
  assign f_zero = (b_i == '0) | (f_ma >= f_mb);

  // two half-width lanes
  logic [VEC_W-1:0] h_ma, h_mb;
  logic [1:0]       h_zero, h_neg;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] la, lb, ma, mb;
    logic          an, bn;
    assign la = a_i[h*HW +: HW];
    assign lb = b_i[h*HW +: HW];
    assign an = sgn_i & la[HW-1];
    assign bn = sgn_i & lb[HW-1];
    assign ma = mag_h(la, an);
    assign mb = mag_h(lb, bn);
    assign h_ma[h*HW +: HW] = ma;
    assign h_mb[h*HW +: HW] = mb;
    assign h_zero[h] = (lb == '0) | (ma >= mb);
    assign h_neg[h]  = an ^ bn;
  end

  assign mag_a_o = quad_i ? f_ma : h_ma;
  assign mag_b_o = quad_i ? f_mb : h_mb;
  assign zero_o  = quad_i ? {1'b0, f_zero} : h_zero;
  assign neg_o   = quad_i ? {1'b0, f_an ^ f_bn} : h_neg;

endmodule

// File: rtl/vxd_step.sv
module vxd_step #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             quad_i,
  input  logic [VEC_W-1:0] rem_i,
  input  logic [VEC_W-1:0] dvs_i,
  input  logic [VEC_W-1:0] quo_i,
  output logic [VEC_W-1:0] rem_o,
  output logic [VEC_W-1:0] quo_o
);
  localparam int unsigned HW = VEC_W / 2;

  // Returns {quotient bit, next partial remainder}. The remainder is always
  // below the divisor, so the difference fits the lane width.
  function automatic logic [VEC_W:0] step_f(input logic [VEC_W-1:0] r, input logic [VEC_W-1:0] d);
    logic [VEC_W-1:0] sh;
    logic             ge;
    sh = {r[VEC_W-2:0], 1'b0};
    ge = r[VEC_W-1] | (sh >= d);
    return {ge, ge ? (sh - d) : sh};
  endfunction

  function automatic logic [HW:0] step_h(input logic [HW-1:0] r, input logic [HW-1:0] d);
    logic [HW-1:0] sh;
    logic          ge;
    sh = {r[HW-2:0], 1'b0};
    ge = r[HW-1] | (sh >= d);
    return {ge, ge ? (sh - d) : sh};
  endfunction

  logic [VEC_W:0]   f_res;
  logic [VEC_W-1:0] h_rem, h_quo;

  assign f_res = step_f(rem_i, dvs_i);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW:0] r;
    assign r = step_h(rem_i[h*HW +: HW], dvs_i[h*HW +: HW]);
    assign h_rem[h*HW +: HW] = r[HW-1:0];
    assign h_quo[h*HW +: HW] = {quo_i[h*HW +: HW-1], r[HW]};
  end

  assign rem_o = quad_i ? f_res[VEC_W-1:0] : h_rem;
  assign quo_o = quad_i ? {quo_i[VEC_W-2:0], f_res[VEC_W]} : h_quo;

endmodule

// File: rtl/vxd_fix.sv
module vxd_fix #(
  parameter int unsigned VEC_W = 128
) (
  input  logic [VEC_W-1:0] quo_i,
  input  logic             quad_i,
  input  logic             sgn_i,
  input  logic [1:0]       neg_i,
  input  logic [1:0]       zero_i,
  output logic [VEC_W-1:0] res_o,
  output logic [1:0]       ovf_o
);
  import vxd_pkg::*;
  localparam int unsigned HW = VEC_W / 2;

  function automatic logic [VEC_W-1:0] sign_f(input logic [VEC_W-1:0] q, input logic n);
    return n ? (~q + 1'b1) : q;
  endfunction

  function automatic logic [HW-1:0] sign_h(input logic [HW-1:0] q, input logic n);
    return n ? (~q + 1'b1) : q;
  endfunction

  logic             f_ovf;
  logic [VEC_W-1:0] f_res, h_res;
  logic [1:0]       h_ovf;

  assign f_ovf = sgn_i & !vxd_fits(quo_i[VEC_W-1], quo_i[VEC_W-2:0] == '0, neg_i[0]);
  assign f_res = (zero_i[0] | f_ovf) ? '0 : sign_f(quo_i, neg_i[0]);

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic [HW-1:0] q;
    logic          ov;
    assign q  = quo_i[h*HW +: HW];
    assign ov = sgn_i & !vxd_fits(q[HW-1], q[HW-2:0] == '0, neg_i[h]);
    assign h_ovf[h] = ov;
    assign h_res[h*HW +: HW] = (zero_i[h] | ov) ? '0 : sign_h(q, neg_i[h]);
  end

  assign res_o = quad_i ? f_res : h_res;
  assign ovf_o = quad_i ? {1'b0, f_ovf} : h_ovf;

endmodule

// File: rtl/vxd_divider.sv
module vxd_divider #(
  parameter int unsigned VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             signed_i,
  input  logic             quad_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [VEC_W-1:0] result_o
);
  import vxd_pkg::*;

  localparam int unsigned HW    = VEC_W / 2;
  localparam int unsigned CNT_W = $clog2(VEC_W);
  localparam logic [CNT_W-1:0] LAST_FULL = CNT_W'(VEC_W - 1);
  localparam logic [CNT_W-1:0] LAST_HALF = CNT_W'(HW - 1);

  vxd_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [VEC_W-1:0] rem_q, quo_q, dvs_q, result_q;
  logic [1:0]       zero_q, neg_q;
  logic             quad_q, sgn_q, done_q;

  // named events for the checker
  logic             accept_w, last_step_w;
  logic [1:0]       ovf_w;

  logic [VEC_W-1:0] pre_ma, pre_mb, rem_n, quo_n, fix_res;
  logic [1:0]       pre_zero, pre_neg;

  assign accept_w    = (state == ST_IDLE) & start_i;
  assign last_step_w = (state == ST_RUN) & (cnt == '0);

  vxd_precheck #(.VEC_W(VEC_W)) u_pre (
    .a_i(a_i), .b_i(b_i), .sgn_i(signed_i), .quad_i(quad_i),
    .mag_a_o(pre_ma), .mag_b_o(pre_mb), .zero_o(pre_zero), .neg_o(pre_neg)
  );

  vxd_step #(.VEC_W(VEC_W)) u_step (
    .quad_i(quad_q), .rem_i(rem_q), .dvs_i(dvs_q), .quo_i(quo_q),
    .rem_o(rem_n), .quo_o(quo_n)
  );

  vxd_fix #(.VEC_W(VEC_W)) u_fix (
    .quo_i(quo_q), .quad_i(quad_q), .sgn_i(sgn_q), .neg_i(neg_q),
    .zero_i(zero_q), .res_o(fix_res), .ovf_o(ovf_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rem_q    <= '0;
      quo_q    <= '0;
      dvs_q    <= '0;
      result_q <= '0;
      zero_q   <= '0;
      neg_q    <= '0;
      quad_q   <= 1'b0;
      sgn_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= (state == ST_FIN);
      case (state)
        ST_IDLE: begin
          if (accept_w) begin
            rem_q  <= pre_ma;
            dvs_q  <= pre_mb;
            quo_q  <= '0;
            zero_q <= pre_zero;
            neg_q  <= pre_neg;
            quad_q <= quad_i;
            sgn_q  <= signed_i;
            cnt    <= quad_i ? LAST_FULL : LAST_HALF;
            state  <= ST_RUN;
          end
        end
        ST_RUN: begin
          rem_q <= rem_n;
          quo_q <= quo_n;
          if (last_step_w) state <= ST_FIN;
          else             cnt   <= cnt - 1'b1;
        end
        ST_FIN: begin
          result_q <= fix_res;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o   = (state != ST_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

// File: rtl/vxd_checker.sv
module vxd_checker #(
  parameter int unsigned VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [VEC_W-1:0] result_o,
  input logic             quad_q,
  input logic [1:0]       zero_q,
  input logic [1:0]       ovf_w,
  input logic             accept_w
);
  localparam int unsigned HW   = VEC_W / 2;
  localparam int unsigned LAT_W = $clog2(VEC_W + 3);
  localparam logic [LAT_W-1:0] LAT_FULL = LAT_W'(VEC_W + 2);
  localparam logic [LAT_W-1:0] LAT_HALF = LAT_W'(HW + 2);

  logic [LAT_W-1:0] lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lat <= '0;
    else if (accept_w) lat <= LAT_W'(1);
    else if (busy_o)   lat <= lat + 1'b1;
  end

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: busy has dropped when done shows
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R8: done arrives N+2 edges after the start edge
  a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lat == (quad_q ? LAT_FULL : LAT_HALF)));

  // R9: busy only rises from a start request
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(start_i));

  // R9: a start while busy neither ends nor restarts the operation early
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

  // R3, R4, R5: a lane flagged at start reports zero (whole-vector lane)
  a_r3_forced_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && quad_q && zero_q[0]) |-> (result_o == '0));

  // R7: an unrepresentable signed quotient reports zero (whole-vector lane)
  a_r7_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && quad_q && ovf_w[0]) |-> (result_o == '0));

  for (genvar h = 0; h < 2; h++) begin : g_lane
    // R3, R4, R5 per half lane
    a_r3_forced_half: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !quad_q && zero_q[h]) |-> (result_o[h*HW +: HW] == '0));
    // R7 per half lane
    a_r7_ovf_half: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !quad_q && ovf_w[h]) |-> (result_o[h*HW +: HW] == '0));
  end

endmodule

bind vxd_divider vxd_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .result_o(result_o), .quad_q(quad_q), .zero_q(zero_q),
  .ovf_w(ovf_w), .accept_w(accept_w)
);

// File: tb/sim_vxd_divider.sv
module sim_vxd_divider;
  localparam int VW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          signed_i = 1'b0;
  logic          quad_i = 1'b0;
  logic [VW-1:0] a_i = '0;
  logic [VW-1:0] b_i = '0;
  wire           busy_o;
  wire           done_o;
  wire [VW-1:0]  result_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  vxd_divider #(.VEC_W(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .quad_i(quad_i), .a_i(a_i), .b_i(b_i), .busy_o(busy_o),
    .done_o(done_o), .result_o(result_o)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference: one lane of width w, computed with 256-bit arithmetic.
  function automatic logic [127:0] ref_lane(input logic [127:0] a, input logic [127:0] b,
                                            input int w, input logic sgn, output string tag);
    logic [255:0] sa, sb, ma, mb, q, lim;
    logic neg;
    if (w == 64) begin
      sa = sgn ? {{192{a[63]}}, a[63:0]} : {192'b0, a[63:0]};
      sb = sgn ? {{192{b[63]}}, b[63:0]} : {192'b0, b[63:0]};
    end else begin
      sa = sgn ? {{128{a[127]}}, a} : {128'b0, a};
      sb = sgn ? {{128{b[127]}}, b} : {128'b0, b};
    end
    ma  = sa[255] ? -sa : sa;
    mb  = sb[255] ? -sb : sb;
    neg = sa[255] ^ sb[255];
    if (mb == 0) begin tag = "R3"; return '0; end
    if (ma >= mb) begin tag = sgn ? "R5" : "R4"; return '0; end
    q = (ma << w) / mb;
    if (sgn) begin
      lim = 256'd1 << (w - 1);
      if (neg ? (q > lim) : (q >= lim)) begin tag = "R7"; return '0; end
    end
    tag = sgn ? "R6" : "R2";
    if (neg) q = -q;
    return (w == 64) ? {64'b0, q[63:0]} : q[127:0];
  endfunction

  function automatic logic [127:0] ref_vec(input logic [127:0] a, input logic [127:0] b,
                                           input logic sgn, input logic quad, output string tag);
    logic [127:0] lo, hi;
    string t0, t1;
    if (quad) return ref_lane(a, b, 128, sgn, tag);
    lo  = ref_lane({64'b0, a[63:0]},   {64'b0, b[63:0]},   64, sgn, t0);
    hi  = ref_lane({64'b0, a[127:64]}, {64'b0, b[127:64]}, 64, sgn, t1);
    tag = {"R1 hi:", t1, " lo:", t0};
    return {hi[63:0], lo[63:0]};
  endfunction

  // Cycle model: counts edges from an accepted start.
  logic         m_busy = 1'b0, m_done = 1'b0;
  logic [127:0] m_res = '0, m_pend = '0, m_tmp;
  int           m_left = 0;
  string        m_tag = "R10", m_rtag = "R10", m_t;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_res <= '0; m_left <= 0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start_i) begin
        m_tmp  = ref_vec(a_i, b_i, signed_i, quad_i, m_t);
        m_pend <= m_tmp;
        m_tag  <= m_t;
        m_busy <= 1'b1;
        m_left <= (quad_i ? 128 : 64) + 1;
      end else if (m_busy) begin
        if (m_left == 1) begin
          m_busy <= 1'b0; m_done <= 1'b1; m_res <= m_pend; m_rtag <= m_tag;
        end
        m_left <= m_left - 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy_o == m_busy, "R8 busy", {127'b0, busy_o}, {127'b0, m_busy});
      chk(done_o == m_done, "R8 done", {127'b0, done_o}, {127'b0, m_done});
      chk(result_o == m_res, m_rtag, result_o, m_res);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic wait_done();
    for (int k = 0; k < 300 && !done_o; k++) @(negedge clk);
  endtask

  task automatic op(input logic [127:0] a, input logic [127:0] b, input logic s,
                    input logic q, input string req);
    logic [127:0] e;
    string t;
    e = ref_vec(a, b, s, q, t);
    @(negedge clk);
    a_i = a; b_i = b; signed_i = s; quad_i = q; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(result_o == e, {req, " ", t}, result_o, e);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    logic [127:0] e9;
    string t9;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy_o == 1'b0, "R10 busy", {127'b0, busy_o}, '0);
    chk(done_o == 1'b0, "R10 done", {127'b0, done_o}, '0);
    chk(result_o == '0, "R10 result", result_o, '0);
    rst_n = 1'b1;

    // R1 / R2: two independent unsigned lanes
    op({64'd1, 64'd3}, {64'd2, 64'd4}, 1'b0, 1'b0, "R1 R2");
    // R3 / R4: zero divisor in lane 1, A >= B in lane 0
    op({64'd5, 64'd9}, {64'd0, 64'd9}, 1'b0, 1'b0, "R3 R4");
    // R6 / R7: -1/2 fits as -2^63, +1/2 overflows
    op({64'hFFFF_FFFF_FFFF_FFFF, 64'd1}, {64'd2, 64'd2}, 1'b1, 1'b0, "R6 R7");
    // R6: mixed signs, in range
    op({64'hFFFF_FFFF_FFFF_FFFF, 64'd1}, {64'd7, 64'hFFFF_FFFF_FFFF_FFF9}, 1'b1, 1'b0, "R6");
    // R5: |A| >= |B| in signed mode
    op({64'd5, 64'hFFFF_FFFF_FFFF_FFFB}, {64'hFFFF_FFFF_FFFF_FFFD, 64'd3}, 1'b1, 1'b0, "R5");
    // R2 quad unsigned
    op(128'd1, 128'd3, 1'b0, 1'b1, "R1 R2 quad");
    // R6 quad signed negative
    op({128{1'b1}}, 128'd3, 1'b1, 1'b1, "R6 quad");
    // R3 quad zero divisor
    op(128'd7, 128'd0, 1'b1, 1'b1, "R3 quad");
    // R5 quad: most negative A against -1
    op({1'b1, 127'b0}, {128{1'b1}}, 1'b1, 1'b1, "R5 quad");
    // R7 quad: 1/2 overflows the signed lane
    op(128'd1, 128'd2, 1'b1, 1'b1, "R7 quad");
    // R4 quad unsigned A == B
    op(128'h1234, 128'h1234, 1'b0, 1'b1, "R4 quad");

    // R9: a second start during busy is ignored
    e9 = ref_vec({64'd3, 64'd1}, {64'd8, 64'd5}, 1'b0, 1'b0, t9);
    @(negedge clk);
    a_i = {64'd3, 64'd1}; b_i = {64'd8, 64'd5}; signed_i = 1'b0; quad_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (10) @(negedge clk);
    a_i = 128'd1; b_i = 128'd3; quad_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(result_o == e9, "R9 result", result_o, e9);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b0, "R9 no second run", {127'b0, busy_o}, '0);

    // Random mix of modes and magnitudes (R2 R4 R5 R6 R7)
    for (int i = 0; i < 40; i++) begin
      logic [63:0] a0, a1, b0, b1;
      a0 = rnd64() >> ($urandom() % 6);
      a1 = rnd64() >> ($urandom() % 6);
      b0 = rnd64();
      b1 = rnd64();
      op({a1, a0}, {b1, b0}, 1'($urandom()), 1'($urandom()), "R2/R6 random");
    end

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule